// File: doc/BRIEF.md
# Vector Register Type Configuration Controller

This block keeps the type configuration for a set of architectural vector data registers. Each register is described by one byte that holds an element width code and an element type code. Bytes are packed into XLEN-wide configuration CSRs. The block also holds three other registers: a global element width cap, a predicate-register count and the active vector length.

Every CSR write is classified and checked against encoding rules and ordering rules. A write that breaks a rule raises a one-cycle illegal pulse and changes nothing. A legal write updates state and tells the external vector storage how much to clear, using one of two outputs:
- a per-register clear mask, or
- a whole-unit clear pulse.

The current maximum vector length (MVL) is derived combinationally from the enabled registers and their widths. A CSR read port returns the stored values.

Top module: `vcfg_ctrl`

## Requirements
- R1: After reset, all configuration bytes, the width cap, the predicate count and the vector length read as zero. MVL is zero, and illegal, the whole-unit clear pulse and the clear mask are all low.
- R2: In each register byte, bits 7:5 are the width code and bits 4:0 are the type code.
  - Width codes: 000 means disabled, 100 means 8 bits, 101 means 16, 110 means 32, 111 means 64, and 011 means 128. A width above ELEN is unsupported, and codes 001 and 010 are unsupported.
  - Type code bits 4:3 give the class: 01 float, 10 signed, 11 unsigned. Type code bits 2:0 give an element width code that must be supported and no wider than the register width. A float type must be at least 16 bits.
  - A disabled register must have type 00000.
  - A write containing any byte that breaks these rules is illegal.
- R3: The address map is as follows:
  - Configuration CSRs sit at addresses 0..7 with a stride of XLEN/32. With XLEN=64, address 0 holds registers 0..7 and address 2 holds registers 8..15, with register n of a CSR in bits 8n+7:8n.
  - Address 8 is the vector length, 9 is the width cap (bits 2:0) and 10 is the predicate count.
  - Any other address, including an odd address when XLEN=64, is illegal.
- R4: A legal configuration CSR write sets every register in higher-numbered configuration CSRs to zero, and sets the predicate count to zero.
- R5: Enabled registers must be contiguous from register 0, and widths must not decrease with the register number. A write that would break either rule is illegal.
- R6: Any legal width cap write pulses the whole-unit clear, even when the value is unchanged, and sets the vector length to 0. A cap with an unsupported code is illegal. A nonzero cap narrower than an enabled register is also illegal.
- R7: While the cap is nonzero, a configuration write that would give any register a width above the cap is illegal.
- R8: While the cap is nonzero, a legal configuration write drives a clear mask covering the written registers and all higher registers. It does not pulse the whole-unit clear. This holds even when no width changes.
- R9: While the cap is zero, a legal configuration write that changes any register's width pulses the whole-unit clear with an all-zero mask. Otherwise it drives the clear mask as in R8. The whole-unit clear and the mask are never active together.
- R10: An illegal write changes no state, drives neither clear output, and leaves the vector length unchanged. The illegal pulse, the whole-unit clear and the mask appear in the cycle after the write and last one cycle.
- R11: A vector length write stores min(value, MVL). A legal configuration write or predicate count write sets the vector length to the resulting MVL. The vector length never exceeds MVL.
- R12: MVL is computed as (STORAGE_BITS / element bits) / number of enabled registers, and is 0 when no register is enabled. The element bits are those of the cap when the cap is nonzero, and otherwise those of the widest enabled register.
- R13: A predicate count write of 0 to 8 is stored. A larger value is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe, one write per cycle |
| csr_addr | input | ADDR_W | Write address |
| csr_wdata | input | XLEN | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | XLEN | Read data, combinational |
| illegal | output | 1 | Rejected-write pulse |
| zero_all | output | 1 | Clear the whole vector unit |
| zero_mask | output | NREGS | Clear the marked data registers |
| vl | output | MVL_W | Active vector length |
| mvl | output | MVL_W | Maximum vector length for the stored configuration |

## Verification
The assertions assume the following about the inputs:
- rst_n is asserted at start-up.
- csr_we is a clean level that is sampled on the clock.
- csr_addr and csr_wdata are stable around the edge where csr_we is high.

Under these assumptions the block's own checks hold for any input: stored bytes stay legal and ordered, the vector length stays within MVL, and an illegal write clears nothing. The stimulus drives every input on the falling edge and pulses csr_we for exactly one cycle per write. It deliberately mixes illegal codes, ordering violations and unknown addresses with legal writes, so that these properties are exercised on both accepted and rejected writes.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

   localparam logic [2:0] RANK_BAD  = 3'd7;
   localparam logic [1:0] CLS_OFF   = 2'b00;
   localparam logic [1:0] CLS_FLOAT = 2'b01;

   localparam int unsigned ADDR_VL    = 8;
   localparam int unsigned ADDR_MAXEW = 9;
   localparam int unsigned ADDR_PRED  = 10;
   localparam int unsigned PRED_MAX   = 8;

   typedef struct packed {
      logic [2:0] wcode;
      logic [4:0] tcode;
   } reg_cfg_t;

   typedef enum logic [2:0] {
      K_CFG,
      K_VL,
      K_MAXEW,
      K_PRED,
      K_BAD
   } csr_kind_e;

   // width code -> size rank (1 = 8 bits ... 5 = 128 bits)
   function automatic logic [2:0] width_rank(input logic [2:0] code);
      case (code)
         3'b000:  return 3'd0;
         3'b100:  return 3'd1;
         3'b101:  return 3'd2;
         3'b110:  return 3'd3;
         3'b111:  return 3'd4;
         3'b011:  return 3'd5;
         default: return RANK_BAD;
      endcase
   endfunction

   function automatic logic [2:0] elen_rank(input int unsigned elen);
      case (elen)
         32:      return 3'd3;
         64:      return 3'd4;
         default: return 3'd5;
      endcase
   endfunction

   function automatic csr_kind_e classify(input int unsigned a,
                                          input int unsigned stride,
                                          input int unsigned ncfg);
      if (a < 8) begin
         if ((a % stride == 0) && (a / stride < ncfg)) return K_CFG;
         return K_BAD;
      end
      case (a)
         ADDR_VL:    return K_VL;
         ADDR_MAXEW: return K_MAXEW;
         ADDR_PRED:  return K_PRED;
         default:    return K_BAD;
      endcase
   endfunction

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
   import vcfg_pkg::*;
#(
   parameter  int unsigned NREGS = 32,
   parameter  int unsigned ELEN  = 64,
   localparam int unsigned CNT_W = $clog2(NREGS + 1)
) (
   input  logic [NREGS*8-1:0] cfg_flat,
   output logic               all_ok,
   output logic               order_ok,
   output logic [2:0]         max_rank,
   output logic [CNT_W-1:0]   n_en
);

   localparam logic [2:0] ELEN_RK = elen_rank(ELEN);

   logic [NREGS-1:0] en;
   logic [NREGS-1:0] byte_ok;
   logic [NREGS-1:0] pair_ok;
   logic [2:0]       rank [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      reg_cfg_t   c;
      logic [2:0] tr;
      assign c       = reg_cfg_t'(cfg_flat[i*8 +: 8]);
      assign rank[i] = width_rank(c.wcode);
      assign tr      = width_rank(c.tcode[2:0]);
      assign en[i]   = |c.wcode;
      assign byte_ok[i] = en[i] ?
         ((rank[i] != RANK_BAD) && (rank[i] <= ELEN_RK) &&
          (c.tcode[4:3] != CLS_OFF) && (tr != RANK_BAD) && (tr != 3'd0) &&
          (tr <= rank[i]) && !((c.tcode[4:3] == CLS_FLOAT) && (tr < 3'd2)))
         : (c.tcode == 5'd0);
      if (i == 0) begin : g_first
         assign pair_ok[i] = 1'b1;
      end else begin : g_rest
         assign pair_ok[i] = !en[i] || (en[i-1] && (rank[i] >= rank[i-1]));
      end
   end

   assign all_ok   = &byte_ok;
   assign order_ok = &pair_ok;

   always_comb begin
      max_rank = 3'd0;
      n_en     = '0;
      for (int i = 0; i < NREGS; i++) begin
         if (en[i]) begin
            n_en = n_en + CNT_W'(1);
            if (rank[i] > max_rank) max_rank = rank[i];
         end
      end
   end

endmodule

// File: rtl/vcfg_mvl.sv
module vcfg_mvl #(
   parameter  int unsigned NREGS        = 32,
   parameter  int unsigned STORAGE_BITS = 16384,
   localparam int unsigned CNT_W        = $clog2(NREGS + 1),
   localparam int unsigned MVL_W        = $clog2(STORAGE_BITS / 8 + 1)
) (
   input  logic [2:0]       eff_rank,
   input  logic [CNT_W-1:0] n_en,
   output logic [MVL_W-1:0] mvl
);

   localparam logic [31:0] STORE = 32'(STORAGE_BITS);

   logic [31:0] per_reg;
   logic [31:0] quot;

   always_comb begin
      per_reg = STORE >> ({29'd0, eff_rank} + 32'd2);
      quot    = '0;
      if ((n_en != '0) && (eff_rank != 3'd0)) quot = per_reg / 32'(n_en);
      mvl = MVL_W'(quot);
   end

endmodule

// File: rtl/vcfg_ctrl.sv
module vcfg_ctrl
   import vcfg_pkg::*;
#(
   parameter  int unsigned NREGS        = 32,
   parameter  int unsigned XLEN         = 64,
   parameter  int unsigned ELEN         = 64,
   parameter  int unsigned STORAGE_BITS = 16384,
   parameter  int unsigned ADDR_W       = 4,
   localparam int unsigned MVL_W        = $clog2(STORAGE_BITS / 8 + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [XLEN-1:0]   csr_wdata,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [XLEN-1:0]   rd_data,
   output logic              illegal,
   output logic              zero_all,
   output logic [NREGS-1:0]  zero_mask,
   output logic [MVL_W-1:0]  vl,
   output logic [MVL_W-1:0]  mvl
);

   localparam int unsigned RPC     = XLEN / 8;
   localparam int unsigned NCFG    = NREGS / RPC;
   localparam int unsigned STRIDE  = XLEN / 32;
   localparam int unsigned CNT_W   = $clog2(NREGS + 1);
   localparam logic [2:0]  ELEN_RK = elen_rank(ELEN);

   if (XLEN != 32 && XLEN != 64) begin : g_chk_xlen
      $error("vcfg_ctrl: XLEN must be 32 or 64");
   end
   if (NREGS % RPC != 0 || NCFG * STRIDE > 8) begin : g_chk_regs
      $error("vcfg_ctrl: NREGS does not fit the configuration CSR window");
   end
   if (ELEN != 32 && ELEN != 64 && ELEN != 128) begin : g_chk_elen
      $error("vcfg_ctrl: ELEN must be 32, 64 or 128");
   end
   if (ADDR_W < 4 || MVL_W > XLEN) begin : g_chk_addr
      $error("vcfg_ctrl: ADDR_W or STORAGE_BITS out of range");
   end

   logic [NREGS*8-1:0] cfg_q;
   logic [2:0]         maxew_q;
   logic [3:0]         pred_q;
   logic [MVL_W-1:0]   vl_q;
   logic               illegal_q, zero_all_q;
   logic [NREGS-1:0]   zero_mask_q;

   // write classification
   csr_kind_e   wkind, rkind;
   int unsigned wr_slot, rd_slot;

   always_comb begin
      wkind   = classify(32'(csr_addr), STRIDE, NCFG);
      rkind   = classify(32'(rd_addr), STRIDE, NCFG);
      wr_slot = (wkind == K_CFG) ? 32'(csr_addr) / STRIDE : 0;
      rd_slot = (rkind == K_CFG) ? 32'(rd_addr) / STRIDE : 0;
   end

   // candidate configuration after a write to slot wr_slot
   logic [NREGS*8-1:0] cand;
   for (genvar s = 0; s < NCFG; s++) begin : g_slot
      always_comb begin
         if (s < wr_slot)       cand[s*XLEN +: XLEN] = cfg_q[s*XLEN +: XLEN];
         else if (s == wr_slot) cand[s*XLEN +: XLEN] = csr_wdata;
         else                   cand[s*XLEN +: XLEN] = '0;
      end
   end

   logic             c_ok, c_order, q_ok, q_order;
   logic [2:0]       c_rank, q_rank;
   logic [CNT_W-1:0] c_nen, q_nen;

   vcfg_decode #(.NREGS(NREGS), .ELEN(ELEN)) u_dec_cand (
      .cfg_flat(cand), .all_ok(c_ok), .order_ok(c_order),
      .max_rank(c_rank), .n_en(c_nen));

   vcfg_decode #(.NREGS(NREGS), .ELEN(ELEN)) u_dec_cur (
      .cfg_flat(cfg_q), .all_ok(q_ok), .order_ok(q_order),
      .max_rank(q_rank), .n_en(q_nen));

   logic [2:0]       cap_rank, q_eff, c_eff;
   logic [MVL_W-1:0] q_mvl, c_mvl;

   assign cap_rank = width_rank(maxew_q);
   assign q_eff    = (maxew_q != 3'd0) ? cap_rank : q_rank;
   assign c_eff    = (maxew_q != 3'd0) ? cap_rank : c_rank;

   vcfg_mvl #(.NREGS(NREGS), .STORAGE_BITS(STORAGE_BITS)) u_mvl_cur (
      .eff_rank(q_eff), .n_en(q_nen), .mvl(q_mvl));

   vcfg_mvl #(.NREGS(NREGS), .STORAGE_BITS(STORAGE_BITS)) u_mvl_cand (
      .eff_rank(c_eff), .n_en(c_nen), .mvl(c_mvl));

   // legality and clear decisions
   logic             cfg_ok, w_changed, cap_ok, pred_ok;
   logic [NREGS-1:0] hi_mask;
   logic [2:0]       new_cap_rank;

   always_comb begin
      w_changed = 1'b0;
      for (int i = 0; i < NREGS; i++) begin
         hi_mask[i] = (i >= wr_slot * RPC);
         if (cfg_q[i*8+5 +: 3] != cand[i*8+5 +: 3]) w_changed = 1'b1;
      end
      cfg_ok = c_ok && c_order && ((maxew_q == 3'd0) || (c_rank <= cap_rank));
      new_cap_rank = width_rank(csr_wdata[2:0]);
      cap_ok = (csr_wdata[2:0] == 3'd0) ||
               ((new_cap_rank != RANK_BAD) && (new_cap_rank <= ELEN_RK) &&
                (new_cap_rank >= q_rank));
      pred_ok = (csr_wdata <= XLEN'(PRED_MAX));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q       <= '0;
         maxew_q     <= '0;
         pred_q      <= '0;
         vl_q        <= '0;
         illegal_q   <= 1'b0;
         zero_all_q  <= 1'b0;
         zero_mask_q <= '0;
      end else begin
         illegal_q   <= 1'b0;
         zero_all_q  <= 1'b0;
         zero_mask_q <= '0;
         if (csr_we) begin
            unique case (wkind)
               K_CFG: begin
                  if (cfg_ok) begin
                     cfg_q  <= cand;
                     pred_q <= '0;
                     vl_q   <= c_mvl;
                     if (maxew_q == 3'd0 && w_changed) zero_all_q  <= 1'b1;
                     else                              zero_mask_q <= hi_mask;
                  end else begin
                     illegal_q <= 1'b1;
                  end
               end
               K_VL: begin
                  if (csr_wdata > XLEN'(q_mvl)) vl_q <= q_mvl;
                  else                          vl_q <= csr_wdata[MVL_W-1:0];
               end
               K_MAXEW: begin
                  if (cap_ok) begin
                     maxew_q    <= csr_wdata[2:0];
                     zero_all_q <= 1'b1;
                     vl_q       <= '0;
                  end else begin
                     illegal_q <= 1'b1;
                  end
               end
               K_PRED: begin
                  if (pred_ok) begin
                     pred_q <= csr_wdata[3:0];
                     vl_q   <= q_mvl;
                  end else begin
                     illegal_q <= 1'b1;
                  end
               end
               default: illegal_q <= 1'b1;
            endcase
         end
      end
   end

   // read path
   always_comb begin
      unique case (rkind)
         K_CFG:   rd_data = cfg_q[rd_slot*XLEN +: XLEN];
         K_VL:    rd_data = XLEN'(vl_q);
         K_MAXEW: rd_data = XLEN'(maxew_q);
         K_PRED:  rd_data = XLEN'(pred_q);
         default: rd_data = '0;
      endcase
   end

   assign illegal   = illegal_q;
   assign zero_all  = zero_all_q;
   assign zero_mask = zero_mask_q;
   assign vl        = vl_q;
   assign mvl       = q_mvl;

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(zero_all && (|zero_mask)));                                        // R9
   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!zero_all && (zero_mask == '0)));                       // R10
   AST_ILLEGAL_VL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> $stable(vl));                                            // R10
   AST_EVENT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal || zero_all || (|zero_mask)) |-> $past(csr_we));            // R10
   AST_VL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      vl <= mvl);                                                          // R11
   AST_STORED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      q_order && q_ok);                                                    // R5
   AST_PRED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pred_q <= 4'(PRED_MAX));                                             // R13
   AST_CAP_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
      (maxew_q != 3'd0) |-> (q_rank <= cap_rank));                         // R7

endmodule

// File: tb/vcfg_ctrl_tb_top.sv
module vcfg_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        csr_we;
   logic [3:0]  csr_addr, rd_addr;
   logic [63:0] csr_wdata, rd_data;
   logic        illegal, zero_all;
   logic [31:0] zero_mask;
   logic [11:0] vl, mvl;

   always #4 clk = ~clk;   // 125 MHz

   vcfg_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
      .illegal(illegal), .zero_all(zero_all), .zero_mask(zero_mask),
      .vl(vl), .mvl(mvl));

   typedef struct {
      logic        ill;
      logic        zall;
      logic [31:0] mask;
      int unsigned evl;
      int unsigned emvl;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;

   task automatic chk(input string tag, input string what,
                      input longint unsigned act, input longint unsigned exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // monitor: compares one expected item per write, after the capturing edge
   always begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         chk(e.tag, "illegal",   illegal,   e.ill);
         chk(e.tag, "zero_all",  zero_all,  e.zall);
         chk(e.tag, "zero_mask", zero_mask, e.mask);
         chk(e.tag, "vl",        vl,        e.evl);
         chk(e.tag, "mvl",       mvl,       e.emvl);
      end
   end

   // driver: one-cycle write plus the expected outcome
   task automatic wr(input logic [3:0] a, input logic [63:0] d,
                     input logic ill, input logic zall, input logic [31:0] mask,
                     input int unsigned evl, input int unsigned emvl,
                     input string tag);
      exp_t e;
      @(negedge clk);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      e.ill = ill; e.zall = zall; e.mask = mask;
      e.evl = evl; e.emvl = emvl; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [63:0] exp, input string tag);
      @(negedge clk);
      rd_addr = a;
      #1;
      chk(tag, "rd_data", rd_data, exp);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   localparam logic [63:0] ALL32 = 64'hD6D6_D6D6_D6D6_D6D6;

   initial begin
      rst_n = 1'b0; csr_we = 1'b0; csr_addr = '0; csr_wdata = '0; rd_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "vl", vl, 0);
      chk("R1", "mvl", mvl, 0);
      chk("R1", "strobes", {illegal, zero_all, zero_mask}, 0);
      rd(4'd0, 64'h0, "R1");
      rd(4'd9, 64'h0, "R1");

      // R2 R9 R12: signed8 + signed16, widths change with cap zero
      wr(4'd0, 64'hB594, 0, 1, 0, 512, 512, "R9_first_cfg");
      rd(4'd0, 64'hB594, "R3");
      wr(4'd8, 64'd1000, 0, 0, 0, 512, 512, "R11_clamp");
      wr(4'd8, 64'd100, 0, 0, 0, 100, 512, "R11_store");
      // R9: same widths, cap zero -> mask only, vl reloads
      wr(4'd0, 64'hB594, 0, 0, 32'hFFFF_FFFF, 512, 512, "R9_unchanged");
      // R5: gap before reg8; R10 nothing changes
      wr(4'd2, 64'hF7, 1, 0, 0, 512, 512, "R5_gap");
      rd(4'd2, 64'h0, "R10");
      wr(4'd0, 64'h94B5, 1, 0, 0, 512, 512, "R5_decreasing");
      rd(4'd0, 64'hB594, "R10");
      // R2 bad encodings
      wr(4'd0, 64'h73, 1, 0, 0, 512, 512, "R2_w128");
      wr(4'd0, 64'h8C, 1, 0, 0, 512, 512, "R2_float8");
      wr(4'd0, 64'h20, 1, 0, 0, 512, 512, "R2_wcode001");
      wr(4'd0, 64'hB6, 1, 0, 0, 512, 512, "R2_type_wider");
      wr(4'd0, 64'hA5, 1, 0, 0, 512, 512, "R2_no_class");
      wr(4'd0, 64'h05, 1, 0, 0, 512, 512, "R2_off_type");
      // R3 bad addresses
      wr(4'd1, 64'h94, 1, 0, 0, 512, 512, "R3_odd_slot");
      wr(4'd11, 64'h1, 1, 0, 0, 512, 512, "R3_unmapped");
      // R13 and R4
      wr(4'd10, 64'd5, 0, 0, 0, 512, 512, "R13_pred5");
      rd(4'd10, 64'd5, "R13");
      wr(4'd0, ALL32, 0, 1, 0, 64, 64, "R12_eight32");
      rd(4'd10, 64'd0, "R4_pred_cleared");
      wr(4'd2, 64'hF7, 0, 1, 0, 28, 28, "R12_nine");
      rd(4'd2, 64'hF7, "R3_slot1");
      wr(4'd10, 64'd5, 0, 0, 0, 28, 28, "R11_pred_reload");
      wr(4'd8, 64'd3, 0, 0, 0, 3, 28, "R11_small");
      wr(4'd0, ALL32, 0, 1, 0, 64, 64, "R4_higher_cleared");
      rd(4'd2, 64'h0, "R4");
      wr(4'd10, 64'd9, 1, 0, 0, 64, 64, "R13_pred9");
      wr(4'd10, 64'd8, 0, 0, 0, 64, 64, "R13_pred8");
      rd(4'd10, 64'd8, "R13");
      // R6 width cap
      wr(4'd9, 64'd5, 1, 0, 0, 64, 64, "R6_cap_narrow");
      wr(4'd9, 64'd2, 1, 0, 0, 64, 64, "R6_cap_badcode");
      wr(4'd9, 64'd6, 0, 1, 0, 0, 64, "R6_cap32");
      wr(4'd9, 64'd6, 0, 1, 0, 0, 64, "R6_cap_same");
      rd(4'd9, 64'd6, "R6");
      // R7, R8
      wr(4'd2, 64'hF7, 1, 0, 0, 0, 64, "R7_over_cap");
      wr(4'd2, 64'hD6, 0, 0, 32'hFFFF_FF00, 56, 56, "R8_reg8");
      wr(4'd2, 64'hD6, 0, 0, 32'hFFFF_FF00, 56, 56, "R8_unchanged");
      wr(4'd0, 64'hD6D6_D6D6_D6D6_D6B5, 0, 0, 32'hFFFF_FFFF, 64, 64, "R8_width_change");
      wr(4'd9, 64'd7, 0, 1, 0, 0, 32, "R12_cap64");
      wr(4'd9, 64'd0, 0, 1, 0, 0, 64, "R6_cap_off");
      wr(4'd0, 64'h0, 0, 1, 0, 0, 0, "R12_none");
      wr(4'd8, 64'd50, 0, 0, 0, 0, 0, "R11_zero_mvl");

      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule